// File: doc/BRIEF.md
# Host Adapter Register Window with Three Indirect RAM Channels

This block is the host-side register set of a network adapter that carries its own shared packet RAM. The host sees eight 16-bit registers on a word-addressed I/O bus. Word 0 is written as a control word and read back as a status word. Word 1 issues commands to the serial modem-management unit. Words 2 to 7 form three indirect channels. Each channel is an address register followed by a data port, and a data-port access reads or writes the shared RAM location that its address register points at.

Each channel has its own 2-bit access mode, taken from the upper six bits of the control word. After each data-port access the mode decides what happens next: the address stays where it is, counts up, or counts down. In the fourth mode the data port goes to an external parameter-storage path instead of the RAM. The control word also drives the board reset, a one-cycle channel-attention pulse, the bus width, two general-purpose pins and the interrupt masks. The status word reports pending interrupts, the busy state of the modem-management unit and the parameter store, and a sticky flag for a dropped command. The RAM is modelled inside the block. Its size is set by a parameter, and the 16-bit channel addresses wrap onto it using their low bits.

Top module: `hostwin_regs`

## Requirements
- R1: After reset every output is low, status reads 0 and all three address registers read 0.
- R2: Word 2+2n reads back the address register of channel n, and word 3+2n is its data port. A RAM word written through one channel can be read through another channel at the same address.
- R3: Channel n takes its mode from control bits [11+2n:10+2n]. In mode 0 a data-port access leaves the address unchanged, and the mode of one channel does not affect the others.
- R4: In mode 1 the address rises by one after every data-port read or write, and it wraps from 0xFFFF to 0x0000.
- R5: In mode 2 the address falls by one after every data-port access, and it wraps from 0x0000 to 0xFFFF.
- R6: In mode 3 a data-port write asserts par_we with par_addr equal to the channel address, and it leaves the RAM unchanged. A read returns par_rdata, and the address does not move.
- R7: When control bit 2 is 0 (8-bit operation), a data-port write changes only the low byte of the RAM word, and data-port reads return 0 in bits [15:8].
- R8: brd_reset follows control bit 0 for as long as that bit stays 1. Writing control bit 1 as 1 gives exactly one cycle of chan_attn. Control bits 3 and 4 drive gp_out[0] and gp_out[1].
- R9: A lan_evt pulse sets status bit 0, and a mgmt_evt pulse sets status bit 1. irq is high exactly when a pending bit is set and its enable is set (control bit 5 for bit 0, bit 6 for bit 1).
- R10: A pending bit, or the dropped flag in status bit 4, is cleared only by a word-0 write that has bit 7 set and a 1 in the same bit position. Without bit 7 the write has no effect on status.
- R11: A word-1 write with bit 0 set gives one cycle of mgmt_start. mgmt_data is taken from bits [15:8] and mgmt_cmd from bits [7:1]. Status bit 2 is then set for MGMT_BUSY_CYC cycles. A word-1 write with bit 0 clear does nothing.
- R12: A word-1 write made while status bit 2 is set is dropped: it gives no pulse and no output change, and it sets status bit 4.
- R13: Status bit 3 mirrors the par_busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word_addr | input | 3 | Register word select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances channel address on data ports) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_word_addr |
| lan_evt | input | 1 | LAN controller interrupt event pulse |
| mgmt_evt | input | 1 | Modem-management interrupt event pulse |
| par_busy | input | 1 | Parameter store busy |
| par_rdata | input | 16 | Parameter store read data |
| par_addr | output | 16 | Parameter store address |
| par_wdata | output | 16 | Parameter store write data |
| par_we | output | 1 | Parameter store write strobe |
| par_re | output | 1 | Parameter store read strobe |
| brd_reset | output | 1 | Board reset level |
| chan_attn | output | 1 | Channel-attention pulse |
| wide_bus | output | 1 | 1 = 16-bit operation |
| gp_out | output | 2 | General-purpose outputs |
| irq | output | 1 | Combined unmasked interrupt |
| mgmt_start | output | 1 | Modem-management command pulse |
| mgmt_cmd | output | 7 | Modem-management command/address |
| mgmt_data | output | 8 | Modem-management data byte |

## Verification
The hardest case to reach from the ports is a modem-management write that arrives while the unit is still busy. The stimulus issues a second command on the very next cycle after a first one. It then counts edges up to the exact last busy cycle and reads status there, before and after the counter runs out. The wrap-around cases need the address register to be loaded with 0xFFFF or 0x0000 right before a data access. Both directions are then read back through a second, static channel to check which RAM word was hit.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;
    typedef enum logic [1:0] {
        PM_HOLD  = 2'd0,
        PM_UP    = 2'd1,
        PM_DOWN  = 2'd2,
        PM_PARAM = 2'd3
    } pmode_e;

    localparam int NCH      = 3;
    localparam int WORD_W   = 16;
    localparam int MODE_LSB = 10;

    localparam int CB_RESET = 0;
    localparam int CB_ATTN  = 1;
    localparam int CB_WIDE  = 2;
    localparam int CB_GP0   = 3;
    localparam int CB_IELAN = 5;
    localparam int CB_IEMGT = 6;
    localparam int CB_CLEN  = 7;

    localparam int SB_DROP  = 4;
endpackage

// File: rtl/hostwin_chan.sv
module hostwin_chan
    import hostwin_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pmode_e        mode,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          acc,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld) begin
            s_d.addr = ld_val;
        end else if (acc) begin
            case (mode)
                PM_UP:   s_d.addr = s_q.addr + AW'(1);
                PM_DOWN: s_d.addr = s_q.addr - AW'(1);
                default: s_d.addr = s_q.addr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ld && (mode == PM_HOLD || mode == PM_PARAM)) |=> $stable(addr)); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ld && mode == PM_UP) |=> addr == AW'($past(addr) + AW'(1))); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ld && mode == PM_DOWN) |=> addr == AW'($past(addr) - AW'(1))); // R5
endmodule

// File: rtl/hostwin_ram.sv
module hostwin_ram
    import hostwin_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              we_hi,
    input  logic [RAM_AW-1:0] idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx][7:0] <= wdata[7:0];
            if (we_hi) mem[idx][15:8] <= wdata[15:8];
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/hostwin_ctl.sv
module hostwin_ctl
    import hostwin_pkg::*;
#(
    parameter int MGMT_BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              mgmt_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              lan_evt,
    input  logic              mgmt_evt,
    input  logic              par_busy,
    output logic [WORD_W-1:0] status,
    output logic [2*NCH-1:0]  modes,
    output logic              brd_reset,
    output logic              chan_attn,
    output logic              wide_bus,
    output logic [1:0]        gp_out,
    output logic              irq,
    output logic              mgmt_start,
    output logic [6:0]        mgmt_cmd,
    output logic [7:0]        mgmt_data
);
    localparam int CW = $clog2(MGMT_BUSY_CYC + 1);

    typedef struct packed {
        logic             rst;
        logic             ca;
        logic             wide;
        logic [1:0]       gp;
        logic [1:0]       ie;
        logic [2*NCH-1:0] modes;
        logic [1:0]       pend;
        logic             drop;
        logic [CW-1:0]    cnt;
        logic             start;
        logic [6:0]       mcmd;
        logic [7:0]       mdata;
    } ctl_t;

    ctl_t s_d, s_q;
    logic busy_q;

    assign busy_q = (s_q.cnt != '0);

    always_comb begin
        s_d       = s_q;
        s_d.ca    = 1'b0;
        s_d.start = 1'b0;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - CW'(1);

        if (cmd_we) begin
            s_d.rst   = wdata[CB_RESET];
            s_d.ca    = wdata[CB_ATTN];
            s_d.wide  = wdata[CB_WIDE];
            s_d.gp    = wdata[CB_GP0+1:CB_GP0];
            s_d.ie    = wdata[CB_IEMGT:CB_IELAN];
            s_d.modes = wdata[MODE_LSB+2*NCH-1:MODE_LSB];
            if (wdata[CB_CLEN]) begin
                s_d.pend = s_q.pend & ~wdata[1:0];
                s_d.drop = s_q.drop & ~wdata[SB_DROP];
            end
        end

        s_d.pend = s_d.pend | {mgmt_evt, lan_evt};

        if (mgmt_we && wdata[0]) begin
            if (busy_q) begin
                s_d.drop = 1'b1;
            end else begin
                s_d.start = 1'b1;
                s_d.mcmd  = wdata[7:1];
                s_d.mdata = wdata[15:8];
                s_d.cnt   = CW'(MGMT_BUSY_CYC);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status     = {11'd0, s_q.drop, par_busy, busy_q, s_q.pend};
    assign modes      = s_q.modes;
    assign brd_reset  = s_q.rst;
    assign chan_attn  = s_q.ca;
    assign wide_bus   = s_q.wide;
    assign gp_out     = s_q.gp;
    assign irq        = |(s_q.pend & s_q.ie);
    assign mgmt_start = s_q.start;
    assign mgmt_cmd   = s_q.mcmd;
    assign mgmt_data  = s_q.mdata;

    AST_ATTN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_attn |-> $past(cmd_we && wdata[CB_ATTN])); // R8
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && wdata[0] && busy_q) |=> (s_q.drop && !mgmt_start && $stable(mgmt_data))); // R12
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start |=> !mgmt_start); // R11
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend[0] && !(cmd_we && wdata[CB_CLEN] && wdata[0])) |=> s_q.pend[0]); // R10
endmodule

// File: rtl/hostwin_regs.sv
module hostwin_regs
    import hostwin_pkg::*;
#(
    parameter int RAM_AW        = 10,
    parameter int MGMT_BUSY_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_word_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        lan_evt,
    input  logic        mgmt_evt,
    input  logic        par_busy,
    input  logic [15:0] par_rdata,
    output logic [15:0] par_addr,
    output logic [15:0] par_wdata,
    output logic        par_we,
    output logic        par_re,
    output logic        brd_reset,
    output logic        chan_attn,
    output logic        wide_bus,
    output logic [1:0]  gp_out,
    output logic        irq,
    output logic        mgmt_start,
    output logic [6:0]  mgmt_cmd,
    output logic [7:0]  mgmt_data
);
    logic [WORD_W-1:0] status;
    logic [2*NCH-1:0]  modes;
    logic [WORD_W-1:0] ch_addr [NCH];
    logic [NCH-1:0]    addr_hit, data_hit;
    logic              any_data;
    logic [WORD_W-1:0] sel_addr;
    pmode_e            sel_mode;
    logic [WORD_W-1:0] ram_rdata, port_rdata;
    logic              ram_we;

    hostwin_ctl #(.MGMT_BUSY_CYC(MGMT_BUSY_CYC)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (bus_wr && bus_word_addr == 3'd0),
        .mgmt_we    (bus_wr && bus_word_addr == 3'd1),
        .wdata      (bus_wdata),
        .lan_evt    (lan_evt),
        .mgmt_evt   (mgmt_evt),
        .par_busy   (par_busy),
        .status     (status),
        .modes      (modes),
        .brd_reset  (brd_reset),
        .chan_attn  (chan_attn),
        .wide_bus   (wide_bus),
        .gp_out     (gp_out),
        .irq        (irq),
        .mgmt_start (mgmt_start),
        .mgmt_cmd   (mgmt_cmd),
        .mgmt_data  (mgmt_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign addr_hit[g] = (bus_word_addr == 3'(2 + 2*g));
        assign data_hit[g] = (bus_word_addr == 3'(3 + 2*g));

        hostwin_chan #(.AW(WORD_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (pmode_e'(modes[2*g+1:2*g])),
            .ld     (bus_wr && addr_hit[g]),
            .ld_val (bus_wdata),
            .acc    ((bus_wr || bus_rd) && data_hit[g]),
            .addr   (ch_addr[g])
        );
    end

    always_comb begin
        any_data = 1'b0;
        sel_addr = '0;
        sel_mode = PM_HOLD;
        for (int i = 0; i < NCH; i++) begin
            if (data_hit[i]) begin
                any_data = 1'b1;
                sel_addr = ch_addr[i];
                sel_mode = pmode_e'(modes[2*i+1 -: 2]);
            end
        end
    end

    assign ram_we    = bus_wr && any_data && (sel_mode != PM_PARAM);
    assign par_we    = bus_wr && any_data && (sel_mode == PM_PARAM);
    assign par_re    = bus_rd && any_data && (sel_mode == PM_PARAM);
    assign par_addr  = sel_addr;
    assign par_wdata = bus_wdata;

    hostwin_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .we_hi (wide_bus),
        .idx   (sel_addr[RAM_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        port_rdata = (sel_mode == PM_PARAM) ? par_rdata : ram_rdata;
        if (!wide_bus) port_rdata[15:8] = 8'd0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_word_addr == 3'd0) bus_rdata = status;
        for (int i = 0; i < NCH; i++) begin
            if (addr_hit[i]) bus_rdata = ch_addr[i];
            if (data_hit[i]) bus_rdata = port_rdata;
        end
    end

    AST_PARAM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, par_we, par_re && bus_wr})); // R6
endmodule

// File: tb/hostwin_regs_test.sv
module hostwin_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_word_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        lan_evt = 1'b0, mgmt_evt = 1'b0, par_busy = 1'b0;
    logic [15:0] par_rdata = 16'hBEEF;
    logic [15:0] par_addr, par_wdata;
    logic        par_we, par_re, brd_reset, chan_attn, wide_bus, irq, mgmt_start;
    logic [1:0]  gp_out;
    logic [6:0]  mgmt_cmd;
    logic [7:0]  mgmt_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hostwin_regs uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_word_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_word_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); check("R1 status", v, 16'h0);
        rd(3'd2, v); check("R1 addr0", v, 16'h0);
        rd(3'd4, v); check("R1 addr1", v, 16'h0);
        rd(3'd6, v); check("R1 addr2", v, 16'h0);
        check("R1 outputs", {brd_reset, chan_attn, wide_bus, gp_out, irq, mgmt_start}, 0);
    endtask

    task automatic t_static_map;
        logic [15:0] v;
        wr(3'd0, 16'h0004);
        wr(3'd2, 16'h0020);
        wr(3'd3, 16'h1234);
        rd(3'd3, v); check("R3 static read", v, 16'h1234);
        rd(3'd2, v); check("R3 static addr", v, 16'h0020);
        wr(3'd4, 16'h0020);
        rd(3'd5, v); check("R2 cross-channel", v, 16'h1234);
        wr(3'd0, 16'h0404);
        wr(3'd4, 16'h0030);
        wr(3'd5, 16'h0001);
        rd(3'd4, v); check("R3 other channel static", v, 16'h0030);
        rd(3'd3, v); rd(3'd2, v); check("R3 ch0 field bits 11:10", v, 16'h0021);
    endtask

    task automatic t_incr;
        logic [15:0] v;
        wr(3'd0, 16'h1004);
        wr(3'd4, 16'h0010);
        wr(3'd5, 16'h1111);
        wr(3'd5, 16'h2222);
        rd(3'd4, v); check("R4 addr after writes", v, 16'h0012);
        wr(3'd4, 16'h0010);
        rd(3'd5, v); check("R4 read first", v, 16'h1111);
        rd(3'd5, v); check("R4 read second", v, 16'h2222);
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'h7777);
        rd(3'd4, v); check("R4 wrap up", v, 16'h0000);
    endtask

    task automatic t_decr;
        logic [15:0] v;
        wr(3'd0, 16'h8004);
        wr(3'd6, 16'h0001);
        wr(3'd7, 16'hAAAA);
        wr(3'd7, 16'hBBBB);
        rd(3'd6, v); check("R5 wrap down", v, 16'hFFFF);
        wr(3'd2, 16'h0000);
        rd(3'd3, v); check("R5 lower word", v, 16'hBBBB);
        wr(3'd2, 16'h0001);
        rd(3'd3, v); check("R5 upper word", v, 16'hAAAA);
    endtask

    task automatic t_param;
        logic [15:0] v;
        wr(3'd0, 16'h0004);
        wr(3'd2, 16'h0040);
        wr(3'd3, 16'h5555);
        wr(3'd0, 16'h0C04);
        @(negedge clk);
        bus_word_addr = 3'd3; bus_wdata = 16'h9999; bus_wr = 1'b1;
        #1 check("R6 par_we", {par_we, par_addr}, {1'b1, 16'h0040});
        @(posedge clk); #1 bus_wr = 1'b0;
        rd(3'd3, v); check("R6 par read", v, 16'hBEEF);
        rd(3'd2, v); check("R6 addr held", v, 16'h0040);
        wr(3'd0, 16'h0004);
        rd(3'd3, v); check("R6 ram untouched", v, 16'h5555);
    endtask

    task automatic t_byte;
        logic [15:0] v;
        wr(3'd0, 16'h0004);
        wr(3'd2, 16'h0050);
        wr(3'd3, 16'hAB12);
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h77CD);
        rd(3'd3, v); check("R7 narrow read", v, 16'h00CD);
        wr(3'd0, 16'h0004);
        rd(3'd3, v); check("R7 high byte kept", v, 16'hABCD);
    endtask

    task automatic t_ctrl;
        wr(3'd0, 16'h001B);
        check("R8 attn+reset+gp", {chan_attn, brd_reset, gp_out}, 4'b1111);
        tick(1);
        check("R8 attn drops, reset holds", {chan_attn, brd_reset}, 2'b01);
        wr(3'd0, 16'h0000);
        check("R8 reset released", {brd_reset, gp_out}, 3'b000);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        @(negedge clk) lan_evt = 1'b1;
        @(negedge clk) lan_evt = 1'b0;
        rd(3'd0, v); check("R9 lan pending", v[1:0], 2'b01);
        check("R9 masked", irq, 1'b0);
        wr(3'd0, 16'h0020);
        check("R9 unmasked irq", irq, 1'b1);
        wr(3'd0, 16'h0021);
        rd(3'd0, v); check("R10 no clear without enable", v[0], 1'b1);
        wr(3'd0, 16'h00A1);
        rd(3'd0, v); check("R10 cleared", {v[0], irq}, 2'b00);
        @(negedge clk) mgmt_evt = 1'b1;
        @(negedge clk) mgmt_evt = 1'b0;
        wr(3'd0, 16'h0040);
        check("R9 mgmt irq", irq, 1'b1);
        wr(3'd0, 16'h00C2);
        rd(3'd0, v); check("R10 mgmt cleared", {v[1], irq}, 2'b00);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_mgmt;
        logic [15:0] v;
        wr(3'd1, 16'h5A0B);
        check("R11 start fields", {mgmt_start, mgmt_data, mgmt_cmd}, {1'b1, 8'h5A, 7'h05});
        wr(3'd1, 16'h3303);
        check("R12 no start while busy", {mgmt_start, mgmt_data}, {1'b0, 8'h5A});
        tick(6);
        rd(3'd0, v); check("R11 last busy cycle", v[2], 1'b1);
        check("R12 drop flag", v[4], 1'b1);
        rd(3'd0, v); check("R11 busy over", v[2], 1'b0);
        wr(3'd1, 16'h1100);
        check("R11 bit0 clear ignored", {mgmt_start, mgmt_data}, {1'b0, 8'h5A});
        wr(3'd0, 16'h0010);
        rd(3'd0, v); check("R10 drop kept without enable", v[4], 1'b1);
        wr(3'd0, 16'h0090);
        rd(3'd0, v); check("R10 drop cleared", v[4], 1'b0);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_par_busy;
        logic [15:0] v;
        par_busy = 1'b1;
        rd(3'd0, v); check("R13 par busy set", v[3], 1'b1);
        par_busy = 1'b0;
        rd(3'd0, v); check("R13 par busy clear", v[3], 1'b0);
    endtask

    initial begin
        fork
            begin
                tick(3);
                @(negedge clk) rst_n = 1'b1;
                t_reset();
                t_static_map();
                t_incr();
                t_decr();
                t_param();
                t_byte();
                t_ctrl();
                t_irq();
                t_mgmt();
                t_par_busy();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule